// File: doc/BRIEF.md
# Soft Error Scan Supervisor

This block is the control layer that sits beside a configuration-memory soft-error detector. It reads a 4-bit mode switch and two active-low pushbuttons. One button starts a scan and the other requests a forced-error self-test. From these it drives the detector's enable, start and force inputs, and it follows the detector's busy, done and error flags to decide what to show and what to do.

Eight LEDs carry the status. Six of them hold a single lit bit that walks around the group to show the logic is alive. One blinks while the detector is enabled. One shows the latched error. When a real scan reports an error, an open-drain reload request is pulled low for a fixed time. This asks the device to reload its configuration in the background. The request is then released to high impedance, and a board pull-up returns the line high.

Every timer comes from one clock. The blink and rotation share a single prescaler, and the button filters, the busy timeout and the reload pulse each have their own parameterised length.

Top module: `sedSupervisor`

## Requirements
- R1: While reset is low and right after it, led reads 8'b0000_0001, detStart and detForce are 0 and reconfigN is released (high impedance).
- R2: detEnable is 1 exactly when modeSw, registered once, equals 4'b1101 with modeSw[3] as the most significant bit. Every other code gives 0.
- R3: led[7] equals detEnable ANDed with a blink state. The blink state starts at 0 and toggles after every BLINK_TICKS prescaler ticks. A tick occurs every TICK_CYCLES clocks.
- R4: led[5:0] is always one-hot. On each prescaler tick the lit bit moves to the next higher index, and it wraps from bit 5 to bit 0.
- R5: Both buttons are active low. They are synchronised through two flops and filtered. A press held for at least DEBOUNCE_CYCLES clocks gives exactly one single-cycle internal pulse, and a shorter glitch gives none.
- R6: A start press while idle and enabled produces one single-cycle detStart pulse. A start press while disabled produces none.
- R7: led[6] clears on the clock edge that first sees detBusy high after a start. It lights two edges after a detDone pulse that carries detErr=1, and it stays off when detErr=0.
- R8: If detBusy does not rise within BUSY_WAIT clocks of detStart, the controller goes back to idle. led[6] keeps its value, and a later start press is accepted.
- R9: Start presses that arrive while a scan is in progress are ignored and do not produce a second detStart.
- R10: A force press while enabled with modeSw[3]=1 produces one single-cycle detForce pulse and lights led[6] on the same edge. It does not drive reconfigN. A force press while disabled is ignored.
- R11: An error latched from a scan drives reconfigN low for exactly RECONFIG_CYCLES clocks, starting on the edge that lights led[6], and then releases it. The request is not driven again until another scan latches an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (12 MHz nominal) |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSw | input | 4 | Mode switch, up = 1 |
| startBtnN | input | 1 | Start-scan pushbutton, active low |
| forceBtnN | input | 1 | Force-error pushbutton, active low |
| detBusy | input | 1 | Detector scan in progress |
| detDone | input | 1 | Detector scan finished, one-cycle pulse |
| detErr | input | 1 | Detector error flag, valid with detDone |
| detEnable | output | 1 | Detector enable |
| detStart | output | 1 | Detector start, one-cycle pulse |
| detForce | output | 1 | Detector forced-error request, one-cycle pulse |
| led | output | 8 | [5:0] rotation, [6] error, [7] enable blink |
| reconfigN | output | 1 | Open-drain reload request, low or high impedance |

## Verification
The walking LEDs, the blink bit and the enable are compared with a timing model on every clock. A wrong prescaler, rotation or mode register therefore shows up within one tick period. A controller stuck outside idle, or a scan that is wrongly accepted, changes the count of detStart or detForce pulses, and the bench compares that count after each press. A mistimed error latch or reload counter shows up as led[6] holding the wrong value two clocks after done. It also shows up as a reconfigN low time that differs from RECONFIG_CYCLES, or as a second low pulse.

// File: rtl/sedSupPkg.sv
package sedSupPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_BUSY,
    ST_SCANNING,
    ST_REPORT,
    ST_RECONFIG
  } supState_t;

  // strobes from the controller into the datapath
  typedef struct packed {
    logic clearErr;
    logic setErr;
    logic loadReconfig;
  } ctrlStrobes_t;

  localparam logic [3:0] ENABLE_CODE = 4'b1101;

endpackage

// File: rtl/sedBtnFilter.sv
module sedBtnFilter #(
  parameter int DEBOUNCE_CYCLES = 120000
) (
  input  logic clk,
  input  logic rstN,
  input  logic btnN,
  output logic pressPulse
);
  localparam int CW = $clog2(DEBOUNCE_CYCLES + 1);

  logic syncA, syncB, stable;
  logic [CW-1:0] cnt;
  logic settle;

  assign settle = (cnt == CW'(DEBOUNCE_CYCLES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA      <= 1'b0;
      syncB      <= 1'b0;
      stable     <= 1'b0;
      cnt        <= '0;
      pressPulse <= 1'b0;
    end else begin
      syncA      <= ~btnN;
      syncB      <= syncA;
      pressPulse <= syncB & ~stable & settle;
      if (syncB == stable) begin
        cnt <= '0;
      end else if (settle) begin
        stable <= syncB;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R5
  press_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    pressPulse |=> !pressPulse);

endmodule

// File: rtl/sedSupCtrl.sv
module sedSupCtrl
  import sedSupPkg::*;
#(
  parameter int BUSY_WAIT = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startPulse,
  input  logic         forcePulse,
  input  logic         enabled,
  input  logic         modeMsb,
  input  logic         detBusy,
  input  logic         detDone,
  input  logic         detErr,
  input  logic         reconfigActive,
  output logic         detStart,
  output logic         detForce,
  output ctrlStrobes_t strobes
);
  localparam int WW = $clog2(BUSY_WAIT + 1);

  supState_t state, stateNext;
  logic [WW-1:0] waitCnt;
  logic errSeen, startNext, forceNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    startNext = 1'b0;
    forceNext = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startPulse && enabled) begin
          startNext = 1'b1;
          stateNext = ST_WAIT_BUSY;
        end else if (forcePulse && enabled && modeMsb) begin
          forceNext      = 1'b1;
          strobes.setErr = 1'b1;
        end
      end
      ST_WAIT_BUSY: begin
        if (detBusy) begin
          strobes.clearErr = 1'b1;
          stateNext        = ST_SCANNING;
        end else if (waitCnt == WW'(BUSY_WAIT - 1)) begin
          stateNext = ST_IDLE;
        end
      end
      ST_SCANNING: if (detDone) stateNext = ST_REPORT;
      ST_REPORT: begin
        if (errSeen) begin
          strobes.setErr       = 1'b1;
          strobes.loadReconfig = 1'b1;
          stateNext            = ST_RECONFIG;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      ST_RECONFIG: if (!reconfigActive) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      waitCnt  <= '0;
      errSeen  <= 1'b0;
      detStart <= 1'b0;
      detForce <= 1'b0;
    end else begin
      state    <= stateNext;
      detStart <= startNext;
      detForce <= forceNext;
      waitCnt  <= (state == ST_WAIT_BUSY) ? waitCnt + 1'b1 : '0;
      if (state == ST_SCANNING && detDone) errSeen <= detErr;
    end
  end

  // R6
  start_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    detStart |=> !detStart);

  // R8
  busy_wait_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT_BUSY) |-> (waitCnt < WW'(BUSY_WAIT)));

  // R9
  no_start_in_scan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SCANNING) |-> !detStart);

  // R10
  force_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    detForce |=> !detForce);

endmodule

// File: rtl/sedSupDatapath.sv
module sedSupDatapath
  import sedSupPkg::*;
#(
  parameter int TICK_CYCLES     = 1500000,
  parameter int BLINK_TICKS     = 4,
  parameter int RECONFIG_CYCLES = 12000,
  parameter int ROT_WIDTH       = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [3:0]           modeSw,
  input  ctrlStrobes_t         strobes,
  output logic                 enabled,
  output logic                 modeMsb,
  output logic                 reqLow,
  output logic [ROT_WIDTH+1:0] ledBits
);
  localparam int PW = $clog2(TICK_CYCLES + 1);
  localparam int BW = $clog2(BLINK_TICKS + 1);
  localparam int RW = $clog2(RECONFIG_CYCLES + 1);

  logic [3:0]           modeQ;
  logic [PW-1:0]        preCnt;
  logic [BW-1:0]        blinkCnt;
  logic [RW-1:0]        recCnt;
  logic [ROT_WIDTH-1:0] rot;
  logic                 blinkOn, errLed, tick;

  assign tick    = (preCnt == PW'(TICK_CYCLES - 1));
  assign enabled = (modeQ == ENABLE_CODE);
  assign modeMsb = modeQ[3];
  assign ledBits = {enabled & blinkOn, errLed, rot};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ    <= '0;
      preCnt   <= '0;
      blinkCnt <= '0;
      blinkOn  <= 1'b0;
      rot      <= ROT_WIDTH'(1);
    end else begin
      modeQ <= modeSw;
      if (tick) begin
        preCnt <= '0;
        rot    <= {rot[ROT_WIDTH-2:0], rot[ROT_WIDTH-1]};
        if (blinkCnt == BW'(BLINK_TICKS - 1)) begin
          blinkCnt <= '0;
          blinkOn  <= ~blinkOn;
        end else begin
          blinkCnt <= blinkCnt + 1'b1;
        end
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errLed <= 1'b0;
      reqLow <= 1'b0;
      recCnt <= '0;
    end else begin
      if (strobes.setErr)        errLed <= 1'b1;
      else if (strobes.clearErr) errLed <= 1'b0;
      if (strobes.loadReconfig) begin
        reqLow <= 1'b1;
        recCnt <= RW'(RECONFIG_CYCLES - 1);
      end else if (reqLow) begin
        if (recCnt == '0) reqLow <= 1'b0;
        else              recCnt <= recCnt - 1'b1;
      end
    end
  end

  // R4
  rot_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(rot) == 1);

  // R11
  req_has_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqLow |-> errLed);

endmodule

// File: rtl/sedSupervisor.sv
module sedSupervisor
  import sedSupPkg::*;
#(
  parameter int TICK_CYCLES     = 1500000,
  parameter int BLINK_TICKS     = 4,
  parameter int DEBOUNCE_CYCLES = 120000,
  parameter int RECONFIG_CYCLES = 12000,
  parameter int BUSY_WAIT       = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] modeSw,
  input  logic       startBtnN,
  input  logic       forceBtnN,
  input  logic       detBusy,
  input  logic       detDone,
  input  logic       detErr,
  output logic       detEnable,
  output logic       detStart,
  output logic       detForce,
  output logic [7:0] led,
  output wire        reconfigN
);
  logic startPulse, forcePulse, enabled, modeMsb, reqLow;
  ctrlStrobes_t strobes;

  sedBtnFilter #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) uStartBtn (
    .clk(clk), .rstN(rstN), .btnN(startBtnN), .pressPulse(startPulse));

  sedBtnFilter #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) uForceBtn (
    .clk(clk), .rstN(rstN), .btnN(forceBtnN), .pressPulse(forcePulse));

  sedSupCtrl #(.BUSY_WAIT(BUSY_WAIT)) uCtrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .forcePulse(forcePulse),
    .enabled(enabled), .modeMsb(modeMsb), .detBusy(detBusy), .detDone(detDone),
    .detErr(detErr), .reconfigActive(reqLow), .detStart(detStart),
    .detForce(detForce), .strobes(strobes));

  sedSupDatapath #(
    .TICK_CYCLES(TICK_CYCLES), .BLINK_TICKS(BLINK_TICKS),
    .RECONFIG_CYCLES(RECONFIG_CYCLES), .ROT_WIDTH(6)
  ) uData (
    .clk(clk), .rstN(rstN), .modeSw(modeSw), .strobes(strobes),
    .enabled(enabled), .modeMsb(modeMsb), .reqLow(reqLow), .ledBits(led));

  assign detEnable = enabled;
  assign reconfigN = reqLow ? 1'b0 : 1'bz;

endmodule

// File: tb/tb_sedSupervisor.sv
`timescale 1ns/1ps
module tb_sedSupervisor;
  localparam int TICK = 8;
  localparam int BLT  = 4;
  localparam int DEB  = 16;
  localparam int RECF = 40;
  localparam int BW   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] modeSw = 4'b0000;
  logic startBtnN = 1'b1, forceBtnN = 1'b1;
  logic detBusy = 1'b0, detDone = 1'b0, detErr = 1'b0;
  logic detEnable, detStart, detForce;
  logic [7:0] led;
  wire reconfigLine;
  pullup (reconfigLine);

  sedSupervisor #(.TICK_CYCLES(TICK), .BLINK_TICKS(BLT), .DEBOUNCE_CYCLES(DEB),
    .RECONFIG_CYCLES(RECF), .BUSY_WAIT(BW)) dut (
    .clk(clk), .rstN(rstN), .modeSw(modeSw), .startBtnN(startBtnN),
    .forceBtnN(forceBtnN), .detBusy(detBusy), .detDone(detDone), .detErr(detErr),
    .detEnable(detEnable), .detStart(detStart), .detForce(detForce), .led(led),
    .reconfigN(reconfigLine));

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // timing reference model, updated on each rising edge
  int preM = 0, btM = 0, rotIdx = 0;
  bit blinkM = 0, enM = 0;
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preM = 0; btM = 0; rotIdx = 0; blinkM = 0; enM = 0;
    end else begin
      enM = (modeSw == 4'b1101);
      if (preM == TICK - 1) begin
        preM = 0;
        rotIdx = (rotIdx + 1) % 6;
        if (btM == BLT - 1) begin btM = 0; blinkM = !blinkM; end
        else btM++;
      end else preM++;
    end
  end

  // monitors and detector model, all on the falling edge
  int startPulses = 0, forcePulses = 0, lowCycles = 0, lowRuns = 0;
  bit prevStart = 0, prevForce = 0, prevLine = 1;
  bit detRespond = 1, errNext = 0, clrPend = 0;
  int busyLen = 20, detCnt = 0, donePend = 0;

  always @(negedge clk) begin
    if (rstN) begin
      chk(led[5:0] == 6'(1 << rotIdx), "R4 rotation", led[5:0], 1 << rotIdx);
      chk(led[7] == (enM & blinkM), "R3 blink", led[7], enM & blinkM);
      chk(detEnable == enM, "R2 enable", detEnable, enM);
      if (detStart) begin
        startPulses++;
        chk(!prevStart, "R6 start width", 2, 1);
      end
      if (detForce) begin
        forcePulses++;
        chk(!prevForce, "R10 force width", 2, 1);
        chk(led[6] == 1'b1, "R10 force lights", led[6], 1);
        chk(reconfigLine === 1'b1, "R10 no reload", reconfigLine, 1);
      end
      prevStart = detStart;
      prevForce = detForce;
      if (reconfigLine === 1'b0) begin
        lowCycles++;
        if (prevLine) lowRuns++;
      end
      prevLine = (reconfigLine !== 1'b0);
      if (clrPend) begin
        chk(led[6] == 1'b0, "R7 clear on busy", led[6], 0);
        clrPend = 0;
      end
      if (donePend > 0) begin
        donePend--;
        if (donePend == 1) chk(led[6] == 1'b0, "R7 not early", led[6], 0);
        if (donePend == 0) chk(led[6] == errNext, "R7 result", led[6], errNext);
      end
      if (detCnt > 0) begin
        detCnt--;
        if (detCnt == 0) begin
          detBusy = 0; detDone = 1; detErr = errNext; donePend = 2;
        end
      end else begin
        detDone = 0;
        if (detStart && detRespond) begin
          detBusy = 1; detCnt = busyLen; clrPend = 1;
        end
      end
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pressStart(input int hold);
    @(negedge clk) startBtnN = 1'b0;
    waitCyc(hold);
    startBtnN = 1'b1;
    waitCyc(DEB + 8);
  endtask

  task automatic pressForce();
    @(negedge clk) forceBtnN = 1'b0;
    waitCyc(DEB + 8);
    forceBtnN = 1'b1;
    waitCyc(DEB + 8);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s0;
    waitCyc(3);
    // R1 reset state
    chk(led == 8'h01, "R1 leds", led, 1);
    chk(reconfigLine === 1'b1, "R1 released", reconfigLine, 1);
    chk(!detStart && !detForce, "R1 pulses", detStart | detForce, 0);
    rstN = 1'b1;
    waitCyc(2);
    chk(led == 8'h01, "R1 after release", led, 1);
    modeSw = 4'b1101;
    waitCyc(100);
    // R5 glitch filtered
    pressStart(5);
    waitCyc(20);
    chk(startPulses == 0, "R5 glitch", startPulses, 0);
    // R6 / R7 clean scan
    errNext = 0; busyLen = 20;
    pressStart(DEB + 8);
    waitCyc(40);
    chk(startPulses == 1, "R6 one start", startPulses, 1);
    chk(led[6] == 0, "R7 no error", led[6], 0);
    chk(lowRuns == 0, "R11 no reload", lowRuns, 0);
    // R7 / R11 error scan
    errNext = 1;
    pressStart(DEB + 8);
    waitCyc(80);
    chk(led[6] == 1, "R7 error lit", led[6], 1);
    chk(lowCycles == RECF, "R11 low time", lowCycles, RECF);
    chk(lowRuns == 1, "R11 one request", lowRuns, 1);
    waitCyc(100);
    chk(lowRuns == 1, "R11 not reissued", lowRuns, 1);
    chk(reconfigLine === 1'b1, "R11 released", reconfigLine, 1);
    // R8 busy timeout
    detRespond = 0; s0 = startPulses;
    pressStart(DEB + 8);
    waitCyc(30);
    chk(startPulses == s0 + 1, "R8 start issued", startPulses, s0 + 1);
    chk(led[6] == 1, "R8 led kept", led[6], 1);
    detRespond = 1; errNext = 0;
    pressStart(DEB + 8);
    waitCyc(40);
    chk(startPulses == s0 + 2, "R8 accepted after", startPulses, s0 + 2);
    chk(led[6] == 0, "R8 scan cleared", led[6], 0);
    // R9 start ignored during scan
    busyLen = 200; s0 = startPulses;
    pressStart(DEB + 8);
    pressStart(DEB + 8);
    waitCyc(200);
    chk(startPulses == s0 + 1, "R9 ignored", startPulses, s0 + 1);
    busyLen = 20;
    // R10 force self-test
    s0 = lowRuns;
    pressForce();
    chk(forcePulses == 1, "R10 force pulse", forcePulses, 1);
    chk(led[6] == 1, "R10 lit", led[6], 1);
    chk(lowRuns == s0, "R10 no reload", lowRuns, s0);
    // disabled modes
    modeSw = 4'b1100;
    waitCyc(3);
    chk(detEnable == 0, "R2 off code", detEnable, 0);
    s0 = startPulses;
    pressStart(DEB + 8);
    chk(startPulses == s0, "R6 disabled start", startPulses, s0);
    pressForce();
    chk(forcePulses == 1, "R10 disabled force", forcePulses, 1);
    modeSw = 4'b0101;
    pressForce();
    chk(forcePulses == 1, "R10 msb low", forcePulses, 1);
    waitCyc(40);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule